// File: doc/BRIEF.md
# Tree Combining Node for a Processor Control Network

This block is one node of a tree that merges integer values offered by many processors. Each node has a local processor port, a configurable number of child links and one parent link. The local processor starts an operation by writing its operand. The operation kind and the operator are taken from the address bits of that write, not from the data. The node then collects the contributions of every enabled child, folds them together with the local operand and sends the result toward the root as a single pulse. Later a value comes back down from the parent. The node turns it into the local result and into one value for each child.

Four kinds of operation are supported. A reduction returns the same value to everyone. A prefix scan gives each position the combination of everything to its left. A suffix scan gives each position the combination of everything to its right. A one-bit global OR is meant for detecting that message routing has finished, or for use as a barrier. The operators are bitwise OR, bitwise XOR, signed maximum, and two forms of addition that both wrap modulo 2^W. A processor can abstain through a mode bit, and a child link can be disabled. In either case that position contributes the identity of the operator. Only one operation is active at a time.

Top module: `cmb_node`

## Requirements
- R1: After reset the node is idle: `busy`, `upValid`, `resValid` and every `chDnValid` bit are 0.
- R2: A write with `wrEn` starts an operation when the node is idle. `wrAddr[4:3]` selects the kind: 0 reduce, 1 prefix, 2 suffix, 3 global OR. `wrAddr[2:0]` selects the operator: 0 OR, 1 XOR, 2 signed max, 3 signed add, 4 unsigned add. Operator codes 5 to 7 are ignored, and `busy` stays 0.
- R3: A write that arrives while an operation is active is ignored. The results reflect only the first write.
- R4: `upValid` pulses for one cycle only after every child with `childOn` set has reported through `chUpValid`. `upData` is the fold of the local operand and the enabled children. Children with `childOn` clear are not awaited and their data is ignored.
- R5: When `abstain` is 1 at the starting write, the local operand is replaced by the identity: 0 for OR, XOR and both adds, and 0x8000_0000 (the most negative value) for max.
- R6: OR and XOR are bitwise. Max compares in two's complement. Both adds wrap modulo 2^W.
- R7: Reduce: on the downward pass `resData` and every enabled child output equal `dnData`.
- R8: Prefix: `resData` equals `dnData`. Child k receives `dnData` folded with the local operand and children 0 to k-1.
- R9: Suffix: `resData` equals all enabled children folded with `dnData`. Child k receives children k+1 to NCH-1 folded with `dnData`.
- R10: Global OR: only bit 0 of each contribution takes part, the operator is forced to OR, and bits W-1:1 of `upData` are 0.
- R11: A `dnValid` sampled while the node waits makes `resValid` and the enabled `chDnValid` bits pulse together for one cycle, at the next edge. `busy` is 0 from that same edge on.
- R12: A `dnValid` that arrives while no upward result is outstanding is ignored: no `resValid` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Local write strobe that starts an operation |
| wrAddr | input | 5 | Kind in bits 4:3, operator in bits 2:0 |
| wrData | input | W | Local operand |
| abstain | input | 1 | Local mode bit: contribute the identity |
| busy | output | 1 | An operation is active |
| resValid | output | 1 | One-cycle pulse: local result ready |
| resData | output | W | Local result |
| childOn | input | NCH | Per-child enable; a disabled child is not awaited |
| chUpValid | input | NCH | Per-child upward report strobe |
| chUpData | input | NCH*W | Upward child values, child k in bits k*W +: W |
| upValid | output | 1 | One-cycle pulse toward the parent |
| upData | output | W | Combined value toward the parent |
| dnValid | input | 1 | Downward value strobe from the parent |
| dnData | input | W | Downward value from the parent |
| chDnValid | output | NCH | Per-child downward strobe |
| chDnData | output | NCH*W | Downward child values, child k in bits k*W +: W |

## Verification
The assertions assume that `childOn` holds steady while an operation is active. They also assume that the parent drives `dnValid` only as single-cycle pulses. The bench drives `childOn` only while the node is idle, and every `dnValid` it drives lasts one cycle. It still sends reports from disabled children, a second write while the node is busy, and a stray `dnValid` while idle, to show that the node ignores them. Child reports are sent both before and after the starting write, so both arrival orders are covered.

// File: rtl/cmbnet_pkg.sv
package cmbnet_pkg;
  localparam int KIND_BITS = 2;
  localparam int OPER_BITS = 3;
  localparam int ADDR_BITS = KIND_BITS + OPER_BITS;

  typedef enum logic [KIND_BITS-1:0] {
    K_REDUCE = 2'd0,
    K_PREFIX = 2'd1,
    K_SUFFIX = 2'd2,
    K_DONE   = 2'd3
  } kind_e;

  typedef enum logic [OPER_BITS-1:0] {
    O_OR   = 3'd0,
    O_XOR  = 3'd1,
    O_MAX  = 3'd2,
    O_SADD = 3'd3,
    O_UADD = 3'd4
  } oper_e;

  localparam logic [OPER_BITS-1:0] OPER_LAST = 3'd4;

  typedef struct packed {
    logic load;
    logic sendUp;
    logic deliver;
  } strobe_t;
endpackage

// File: rtl/cmb_ctrl.sv
module cmb_ctrl
  import cmbnet_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [OPER_BITS-1:0] operSel,
  input  logic [NCH-1:0]       childOn,
  input  logic [NCH-1:0]       chUpValid,
  input  logic                 dnValid,
  output strobe_t              strb,
  output logic [NCH-1:0]       chCap,
  output logic                 busy
);
  typedef enum logic [1:0] {S_IDLE, S_GATHER, S_WAITDN} state_e;

  state_e         stQ;
  logic [NCH-1:0] got;
  logic           allIn;

  assign allIn = &(got | ~childOn);
  assign chCap = chUpValid & childOn & ~got & {NCH{stQ != S_WAITDN}};

  always_comb begin
    strb         = '0;
    strb.load    = wrEn && (stQ == S_IDLE) && (operSel <= OPER_LAST);
    strb.sendUp  = (stQ == S_GATHER) && allIn;
    strb.deliver = (stQ == S_WAITDN) && dnValid;
  end

  assign busy = (stQ != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ <= S_IDLE;
      got <= '0;
    end else begin
      if (strb.deliver) got <= '0;
      else              got <= got | chCap;
      unique case (stQ)
        S_IDLE:   if (strb.load)    stQ <= S_GATHER;
        S_GATHER: if (strb.sendUp)  stQ <= S_WAITDN;
        S_WAITDN: if (strb.deliver) stQ <= S_IDLE;
        default:                    stQ <= S_IDLE;
      endcase
    end
  end

  // R4: the node reaches the waiting state only with every enabled child in
  p_wait_complete_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == S_WAITDN) |-> &(got | ~childOn));

  // R2: a reserved operator code never leaves the idle state
  p_reserved_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((stQ == S_IDLE) && wrEn && (operSel > OPER_LAST)) |=> (stQ == S_IDLE));
endmodule

// File: rtl/cmb_dpath.sv
module cmb_dpath
  import cmbnet_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [NCH-1:0]       chCap,
  input  logic [ADDR_BITS-1:0] wrAddr,
  input  logic [W-1:0]         wrData,
  input  logic                 abstain,
  input  logic [NCH-1:0]       childOn,
  input  logic [NCH*W-1:0]     chUpData,
  input  logic [W-1:0]         dnData,
  output logic                 upValid,
  output logic [W-1:0]         upData,
  output logic                 resValid,
  output logic [W-1:0]         resData,
  output logic [NCH-1:0]       chDnValid,
  output logic [NCH*W-1:0]     chDnData
);
  localparam int NPOS = NCH + 1;

  kind_e      kindQ;
  oper_e      operQ;
  logic [W-1:0] locRaw;
  logic       locAbsQ;
  logic [W-1:0] chRaw  [NCH];

  oper_e      opEff;
  logic [W-1:0] identV;
  logic [W-1:0] vals [NPOS];
  logic [W-1:0] pre  [NPOS+1];
  logic [W-1:0] suf  [NPOS+1];
  logic [W-1:0] locDn;
  logic [W-1:0] chDnNext [NCH];

  function automatic logic [W-1:0] fold(oper_e o, logic [W-1:0] a, logic [W-1:0] b);
    unique case (o)
      O_OR:    fold = a | b;
      O_XOR:   fold = a ^ b;
      O_MAX:   fold = ($signed(a) > $signed(b)) ? a : b;
      default: fold = a + b;
    endcase
  endfunction

  function automatic logic [W-1:0] shape(kind_e k, logic [W-1:0] x);
    shape = (k == K_DONE) ? {{(W-1){1'b0}}, x[0]} : x;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ   <= K_REDUCE;
      operQ   <= O_OR;
      locRaw  <= '0;
      locAbsQ <= 1'b0;
      for (int k = 0; k < NCH; k++) chRaw[k] <= '0;
    end else begin
      if (strb.load) begin
        kindQ   <= kind_e'(wrAddr[ADDR_BITS-1:OPER_BITS]);
        operQ   <= oper_e'(wrAddr[OPER_BITS-1:0]);
        locRaw  <= wrData;
        locAbsQ <= abstain;
      end
      for (int k = 0; k < NCH; k++)
        if (chCap[k]) chRaw[k] <= chUpData[k*W +: W];
    end
  end

  assign opEff  = (kindQ == K_DONE) ? O_OR : operQ;
  assign identV = (opEff == O_MAX) ? {1'b1, {(W-1){1'b0}}} : '0;

  always_comb begin
    vals[0] = locAbsQ ? identV : shape(kindQ, locRaw);
    for (int k = 0; k < NCH; k++)
      vals[k+1] = childOn[k] ? shape(kindQ, chRaw[k]) : identV;
    pre[0] = identV;
    for (int j = 0; j < NPOS; j++) pre[j+1] = fold(opEff, pre[j], vals[j]);
    suf[NPOS] = identV;
    for (int j = NPOS - 1; j >= 0; j--) suf[j] = fold(opEff, vals[j], suf[j+1]);
  end

  assign locDn = (kindQ == K_SUFFIX) ? fold(opEff, suf[1], dnData) : dnData;

  for (genvar k = 0; k < NCH; k++) begin : g_down
    assign chDnNext[k] =
      (kindQ == K_PREFIX) ? fold(opEff, dnData, pre[k+1]) :
      (kindQ == K_SUFFIX) ? fold(opEff, suf[k+2], dnData) : dnData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upValid   <= 1'b0;
      upData    <= '0;
      resValid  <= 1'b0;
      resData   <= '0;
      chDnValid <= '0;
      chDnData  <= '0;
    end else begin
      upValid   <= strb.sendUp;
      resValid  <= strb.deliver;
      chDnValid <= strb.deliver ? childOn : '0;
      if (strb.sendUp) upData <= pre[NPOS];
      if (strb.deliver) begin
        resData <= locDn;
        for (int k = 0; k < NCH; k++) chDnData[k*W +: W] <= chDnNext[k];
      end
    end
  end

  // R4: the upward strobe is a single-cycle pulse
  p_up_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    upValid |=> !upValid);

  // R11: the local result strobe is a single-cycle pulse
  p_res_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  // R10: a global-OR result carries nothing above bit 0
  p_done_bit0_r10: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && kindQ == K_DONE) |-> (upData[W-1:1] == '0));
endmodule

// File: rtl/cmb_node.sv
module cmb_node
  import cmbnet_pkg::*;
#(
  parameter int W   = 32,
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [4:0]       wrAddr,
  input  logic [W-1:0]     wrData,
  input  logic             abstain,
  output logic             busy,
  output logic             resValid,
  output logic [W-1:0]     resData,
  input  logic [NCH-1:0]   childOn,
  input  logic [NCH-1:0]   chUpValid,
  input  logic [NCH*W-1:0] chUpData,
  output logic             upValid,
  output logic [W-1:0]     upData,
  input  logic             dnValid,
  input  logic [W-1:0]     dnData,
  output logic [NCH-1:0]   chDnValid,
  output logic [NCH*W-1:0] chDnData
);
  strobe_t        strb;
  logic [NCH-1:0] chCap;

  cmb_ctrl #(.NCH(NCH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .operSel   (wrAddr[OPER_BITS-1:0]),
    .childOn   (childOn),
    .chUpValid (chUpValid),
    .dnValid   (dnValid),
    .strb      (strb),
    .chCap     (chCap),
    .busy      (busy)
  );

  cmb_dpath #(.W(W), .NCH(NCH)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .chCap     (chCap),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .abstain   (abstain),
    .childOn   (childOn),
    .chUpData  (chUpData),
    .dnData    (dnData),
    .upValid   (upValid),
    .upData    (upData),
    .resValid  (resValid),
    .resData   (resData),
    .chDnValid (chDnValid),
    .chDnData  (chDnData)
  );

  // R4: a result only goes up while an operation is active
  p_up_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    upValid |-> busy);

  // R11: the node is idle once the local result appears
  p_res_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !busy);

  // R7: children are served in the same cycle as the local processor
  p_dn_with_res_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|chDnValid) |-> resValid);
endmodule

// File: tb/cmb_node_tb.sv
module cmb_node_tb;
  localparam int W = 32;
  localparam int NCH = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic abstain = 1'b0;
  logic busy, resValid, upValid;
  logic [W-1:0] resData, upData;
  logic [NCH-1:0] childOn = '0;
  logic [NCH-1:0] chUpValid = '0;
  logic [NCH*W-1:0] chUpData = '0;
  logic dnValid = 1'b0;
  logic [W-1:0] dnData = '0;
  logic [NCH-1:0] chDnValid;
  logic [NCH*W-1:0] chDnData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  cmb_node #(.W(W), .NCH(NCH)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .abstain(abstain), .busy(busy), .resValid(resValid), .resData(resData),
    .childOn(childOn), .chUpValid(chUpValid), .chUpData(chUpData),
    .upValid(upValid), .upData(upData), .dnValid(dnValid), .dnData(dnData),
    .chDnValid(chDnValid), .chDnData(chDnData)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] tbFold(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    case (o)
      3'd0: return a | b;
      3'd1: return a ^ b;
      3'd2: return ($signed(a) > $signed(b)) ? a : b;
      default: return a + b;
    endcase
  endfunction

  task automatic sendChildren(input logic [W-1:0] c0, input logic [W-1:0] c1);
    @(negedge clk);
    chUpData  = {c1, c0};
    chUpValid = 2'b11;
    @(negedge clk);
    chUpValid = 2'b00;
  endtask

  // One full upward and downward pass with self-computed expectations
  task automatic runOp(input string req, input logic [1:0] kind, input logic [2:0] op,
                       input logic [W-1:0] lv, input logic la,
                       input logic [W-1:0] c0, input logic [W-1:0] c1,
                       input logic [1:0] en, input logic early, input logic intrude,
                       input logic [W-1:0] dn);
    logic [2:0] eo;
    logic [W-1:0] id, v0, v1, v2, eUp, eRes, e0, e1;
    logic seen;
    eo = (kind == 2'd3) ? 3'd0 : op;
    id = (eo == 3'd2) ? 32'h8000_0000 : 32'h0;
    v0 = la ? id : ((kind == 2'd3) ? {31'b0, lv[0]} : lv);
    v1 = en[0] ? ((kind == 2'd3) ? {31'b0, c0[0]} : c0) : id;
    v2 = en[1] ? ((kind == 2'd3) ? {31'b0, c1[0]} : c1) : id;
    eUp = tbFold(eo, tbFold(eo, v0, v1), v2);
    case (kind)
      2'd1: begin eRes = dn; e0 = tbFold(eo, dn, v0); e1 = tbFold(eo, tbFold(eo, dn, v0), v1); end
      2'd2: begin eRes = tbFold(eo, tbFold(eo, v1, v2), dn); e0 = tbFold(eo, v2, dn); e1 = dn; end
      default: begin eRes = dn; e0 = dn; e1 = dn; end
    endcase

    @(negedge clk);
    childOn = en;
    if (early) sendChildren(c0, c1);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = {kind, op}; wrData = lv; abstain = la;
    @(negedge clk);
    wrEn = 1'b0; abstain = 1'b0;
    if (intrude) begin
      wrEn = 1'b1; wrAddr = {2'd0, 3'd1}; wrData = 32'hDEAD_BEEF;
      @(negedge clk);
      wrEn = 1'b0;
    end
    if (!early) begin
      repeat (3) @(negedge clk);
      chk({req, " R4 no upValid before children"}, {31'b0, upValid}, 32'h0);
      sendChildren(c0, c1);
    end
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(posedge clk); #1;
      if (upValid) seen = 1'b1;
    end
    chk({req, " R4 upValid seen"}, {31'b0, seen}, 32'h1);
    chk({req, " R4/R6 upData"}, upData, eUp);

    @(negedge clk);
    dnValid = 1'b1; dnData = dn;
    @(posedge clk); #1;
    dnValid = 1'b0;
    chk({req, " R11 resValid"}, {31'b0, resValid}, 32'h1);
    chk({req, " R11 chDnValid"}, {30'b0, chDnValid}, {30'b0, en});
    chk({req, " R11 busy cleared"}, {31'b0, busy}, 32'h0);
    chk({req, " resData"}, resData, eRes);
    if (en[0]) chk({req, " child0 down"}, chDnData[W-1:0], e0);
    if (en[1]) chk({req, " child1 down"}, chDnData[2*W-1:W], e1);
    @(posedge clk); #1;
    chk({req, " R11 resValid one cycle"}, {31'b0, resValid}, 32'h0);
  endtask

  task automatic testReset();
    chk("R1 busy", {31'b0, busy}, 32'h0);
    chk("R1 upValid", {31'b0, upValid}, 32'h0);
    chk("R1 resValid", {31'b0, resValid}, 32'h0);
    chk("R1 chDnValid", {30'b0, chDnValid}, 32'h0);
  endtask

  task automatic testReserved();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = {2'd0, 3'd6}; wrData = 32'h1234;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R2 reserved operator leaves node idle", {31'b0, busy}, 32'h0);
  endtask

  task automatic testStrayDown();
    logic seen;
    @(negedge clk);
    dnValid = 1'b1; dnData = 32'h5555_AAAA;
    @(negedge clk);
    dnValid = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      if (resValid || chDnValid != 0) seen = 1'b1;
    end
    chk("R12 stray dnValid ignored", {31'b0, seen}, 32'h0);
    chk("R12 still idle", {31'b0, busy}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    runOp("R7 reduce OR", 2'd0, 3'd0, 32'h0000_00F0, 1'b0, 32'h0F00_0000, 32'h0000_0003, 2'b11, 1'b1, 1'b0, 32'hCAFE_0001);
    runOp("R6 reduce XOR", 2'd0, 3'd1, 32'hFF00_FF00, 1'b0, 32'h0F0F_0F0F, 32'h1111_1111, 2'b11, 1'b0, 1'b0, 32'h0000_0042);
    runOp("R8 prefix uadd wrap", 2'd1, 3'd4, 32'hFFFF_FFF0, 1'b0, 32'h0000_0020, 32'h0000_0005, 2'b11, 1'b1, 1'b0, 32'h0000_0100);
    runOp("R9 suffix sadd", 2'd2, 3'd3, 32'hFFFF_FFFE, 1'b0, 32'hFFFF_FFFD, 32'h0000_0009, 2'b11, 1'b0, 1'b0, 32'h0000_0010);
    runOp("R5 max abstain", 2'd0, 3'd2, 32'h7FFF_FFFF, 1'b1, 32'hFFFF_FF00, 32'hFFFF_F000, 2'b11, 1'b1, 1'b0, 32'h1);
    runOp("R8 max prefix signed", 2'd1, 3'd2, 32'h8000_0005, 1'b0, 32'h0000_0007, 32'hFFFF_FFFF, 2'b11, 1'b0, 1'b0, 32'h8000_0000);
    runOp("R4 disabled child", 2'd1, 3'd1, 32'h0000_00AA, 1'b0, 32'h0000_5500, 32'hFFFF_FFFF, 2'b01, 1'b0, 1'b0, 32'h0000_0001);
    runOp("R10 global OR", 2'd3, 3'd3, 32'hFFFF_FFFE, 1'b0, 32'h0000_0001, 32'hAAAA_AAAA, 2'b11, 1'b1, 1'b0, 32'h0000_0001);
    runOp("R10 global OR all zero", 2'd3, 3'd0, 32'hFFFF_FFFE, 1'b0, 32'h0000_0002, 32'h0000_0004, 2'b11, 1'b0, 1'b0, 32'h0);
    runOp("R5 add abstain", 2'd2, 3'd4, 32'h0000_0005, 1'b1, 32'h0000_0003, 32'h0000_0004, 2'b11, 1'b1, 1'b0, 32'h0000_0100);
    runOp("R3 write while busy", 2'd0, 3'd0, 32'h0000_0011, 1'b0, 32'h0000_0100, 32'h0000_2000, 2'b11, 1'b0, 1'b1, 32'h0000_0077);
    testReserved();
    testStrayDown();
    runOp("R7 no children", 2'd0, 3'd4, 32'h0000_0009, 1'b0, 32'h1, 32'h2, 2'b00, 1'b1, 1'b0, 32'h0000_0033);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule